// File: doc/BRIEF.md
# Flash Access Range Guard

This block sits beside a serial-flash sequencer and decides, for each flash cycle the sequencer is about to start, whether that cycle may proceed. It holds a floor address and a small bank of write-protect windows. A cycle whose address is below the floor is refused, whether it reads or writes. A cycle flagged as a write or erase is also refused if its address lands inside any enabled window. The sequencer drops a refused cycle and reports a blocked-access status.

The floor and the windows are programmed through a simple indexed register port with a write strobe and a combinational read-back. Writing 1 to the lock bit in the control register freezes every register until reset. Each window holds a base page and a limit page of 4 KiB. The limit is inclusive, so a window covers the base page through the last byte of the limit page.

Top module: `flash_guard`

## Requirements
- R1: After reset, every register reads 0 (lock clear, floor 0, all windows disabled), and res_valid and res_blocked are 0.
- R2: While unlocked, a write with cfg_wr high updates the register at cfg_idx at the clock edge, and cfg_rdata returns it. Index 0 is control, with the lock in bit 0. Index 1 is the floor, held in bits [23:0]. Indices 2 to 5 are windows 0 to 3, each with enable in bit 31, limit page in bits [27:16] and base page in bits [11:0]. All other bits read 0.
- R3: A window whose enable bit is 0 never blocks a cycle.
- R4: A write or erase cycle is blocked when its address lies from base*4096 up to and including limit*4096+4095 of an enabled window. A window whose limit page is below its base page covers nothing.
- R5: A read cycle (chk_wr low) is never blocked by a window.
- R6: A cycle of either kind whose address is below the floor is blocked. An address equal to the floor is not blocked by the floor.
- R7: Each window is checked on its own, and a hit in any one enabled window blocks the cycle.
- R8: Writing 1 to control bit 0 sets the lock. Once set, it stays set until reset, every later register write is ignored, and read-back still returns the current values.
- R9: A request with chk_valid high produces res_valid high on the next cycle, with res_blocked giving the decision. When res_valid is low, res_blocked is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_idx | input | IDX_W (3) | Register index for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read-back of the register at cfg_idx |
| chk_valid | input | 1 | A flash cycle is presented for checking |
| chk_addr | input | ADDR_W (24) | Flash byte address of the cycle |
| chk_wr | input | 1 | The cycle writes or erases |
| res_valid | output | 1 | Decision is present |
| res_blocked | output | 1 | The cycle must not be issued |

## Verification
The bench goes after the edges of each window: the last byte before the base page, the first byte of the base page, the last byte of the limit page and the first byte past it. A design that compared the limit exclusively, or against the page's first byte, would pass or block the wrong one of these. It probes the floor at floor-1 and at floor exactly, and with reads as well as writes, which catches an off-by-one compare and a floor applied only to writes. It also covers a disabled window and an inverted window, and after the lock it tries writes to the floor, to a window and a 0 to the lock bit. A design with a leaky lock would change the read-back or the blocking decisions.

// File: rtl/fg_pkg.sv
package fg_pkg;
   // register word width of the programming port
   localparam int FG_REG_W        = 32;
   // register index assignment
   localparam int FG_CTRL_IDX     = 0;
   localparam int FG_FLOOR_IDX    = 1;
   localparam int FG_WIN_BASE_IDX = 2;
   // control register
   localparam int FG_LOCK_BIT     = 0;
   // window register layout
   localparam int FG_EN_BIT       = 31;
   localparam int FG_LIM_LSB      = 16;
   localparam int FG_BASE_LSB     = 0;
endpackage

// File: rtl/fg_regs.sv
module fg_regs
   import fg_pkg::*;
#(
   parameter int ADDR_W   = 24,
   parameter int PAGE_W   = 12,
   parameter int NUM_WIN  = 4,
   parameter int IDX_W    = 3
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [IDX_W-1:0]                  idx,
   input  logic [FG_REG_W-1:0]               wr_data,
   output logic [FG_REG_W-1:0]               rd_data,
   output logic                              locked,
   output logic [ADDR_W-1:0]                 floor_addr,
   output logic [NUM_WIN-1:0]                win_en,
   output logic [NUM_WIN-1:0][PAGE_W-1:0]    win_base,
   output logic [NUM_WIN-1:0][PAGE_W-1:0]    win_lim
);
   localparam logic [IDX_W-1:0] CTRL_SEL  = IDX_W'(FG_CTRL_IDX);
   localparam logic [IDX_W-1:0] FLOOR_SEL = IDX_W'(FG_FLOOR_IDX);

   logic wr_ok;
   logic lock_q;
   logic [ADDR_W-1:0] floor_q;

   assign wr_ok = wr_en & ~lock_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q <= 1'b0;
      end else if (wr_ok && idx == CTRL_SEL) begin
         lock_q <= lock_q | wr_data[FG_LOCK_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         floor_q <= '0;
      end else if (wr_ok && idx == FLOOR_SEL) begin
         floor_q <= wr_data[ADDR_W-1:0];
      end
   end

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      localparam logic [IDX_W-1:0] MY_SEL = IDX_W'(FG_WIN_BASE_IDX + g);
      logic              en_q;
      logic [PAGE_W-1:0] base_q;
      logic [PAGE_W-1:0] lim_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en_q   <= 1'b0;
            base_q <= '0;
            lim_q  <= '0;
         end else if (wr_ok && idx == MY_SEL) begin
            en_q   <= wr_data[FG_EN_BIT];
            base_q <= wr_data[FG_BASE_LSB +: PAGE_W];
            lim_q  <= wr_data[FG_LIM_LSB +: PAGE_W];
         end
      end

      assign win_en[g]   = en_q;
      assign win_base[g] = base_q;
      assign win_lim[g]  = lim_q;
   end

   always_comb begin
      rd_data = '0;
      if (idx == CTRL_SEL) begin
         rd_data[FG_LOCK_BIT] = lock_q;
      end else if (idx == FLOOR_SEL) begin
         rd_data[ADDR_W-1:0] = floor_q;
      end else begin
         for (int i = 0; i < NUM_WIN; i++) begin
            if (idx == IDX_W'(FG_WIN_BASE_IDX + i)) begin
               rd_data[FG_EN_BIT]               = win_en[i];
               rd_data[FG_LIM_LSB +: PAGE_W]    = win_lim[i];
               rd_data[FG_BASE_LSB +: PAGE_W]   = win_base[i];
            end
         end
      end
   end

   assign locked     = lock_q;
   assign floor_addr = floor_q;

   // R8
   lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> lock_q);

   // R8
   floor_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> $stable(floor_q));

   // R8
   win_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock_q |=> ($stable(win_en) && $stable(win_base) && $stable(win_lim)));
endmodule

// File: rtl/fg_window.sv
module fg_window #(
   parameter int PAGE_W = 12
) (
   input  logic              en,
   input  logic [PAGE_W-1:0] base_pg,
   input  logic [PAGE_W-1:0] lim_pg,
   input  logic [PAGE_W-1:0] addr_pg,
   input  logic              is_wr,
   output logic              hit
);
   logic above_base;
   logic within_lim;

   // comparing page numbers treats the limit's low offset bits as all ones
   assign above_base = (addr_pg >= base_pg);
   assign within_lim = (addr_pg <= lim_pg);
   assign hit        = en & is_wr & above_base & within_lim;
endmodule

// File: rtl/fg_floor.sv
module fg_floor #(
   parameter int ADDR_W = 24
) (
   input  logic [ADDR_W-1:0] floor_addr,
   input  logic [ADDR_W-1:0] addr,
   output logic              below
);
   assign below = (addr < floor_addr);
endmodule

// File: rtl/flash_guard.sv
module flash_guard
   import fg_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int PAGE_BITS  = 12,
   parameter int NUM_WIN    = 4,
   parameter int IDX_W      = 3,
   parameter bit REG_RESULT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [IDX_W-1:0]     cfg_idx,
   input  logic [FG_REG_W-1:0]  cfg_wdata,
   output logic [FG_REG_W-1:0]  cfg_rdata,
   input  logic                 chk_valid,
   input  logic [ADDR_W-1:0]    chk_addr,
   input  logic                 chk_wr,
   output logic                 res_valid,
   output logic                 res_blocked
);
   localparam int PAGE_W = ADDR_W - PAGE_BITS;

   if (NUM_WIN < 1) begin : g_bad_nwin
      $error("flash_guard: NUM_WIN must be at least 1");
   end
   if (FG_WIN_BASE_IDX + NUM_WIN > (1 << IDX_W)) begin : g_bad_idx
      $error("flash_guard: IDX_W too narrow for NUM_WIN windows");
   end
   if (PAGE_W < 1 || PAGE_W > FG_LIM_LSB || FG_LIM_LSB + PAGE_W > FG_EN_BIT) begin : g_bad_page
      $error("flash_guard: page field does not fit the window register");
   end
   if (ADDR_W > FG_REG_W) begin : g_bad_addr
      $error("flash_guard: ADDR_W exceeds register width");
   end

   logic                           locked;
   logic [ADDR_W-1:0]              floor_addr;
   logic [NUM_WIN-1:0]             win_en;
   logic [NUM_WIN-1:0][PAGE_W-1:0] win_base;
   logic [NUM_WIN-1:0][PAGE_W-1:0] win_lim;
   logic [NUM_WIN-1:0]             win_hit;
   logic                           below_floor;
   logic                           deny;
   logic                           unused_lock;

   fg_regs #(
      .ADDR_W (ADDR_W),
      .PAGE_W (PAGE_W),
      .NUM_WIN(NUM_WIN),
      .IDX_W  (IDX_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (cfg_wr),
      .idx       (cfg_idx),
      .wr_data   (cfg_wdata),
      .rd_data   (cfg_rdata),
      .locked    (locked),
      .floor_addr(floor_addr),
      .win_en    (win_en),
      .win_base  (win_base),
      .win_lim   (win_lim)
   );

   assign unused_lock = locked;

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
      fg_window #(.PAGE_W(PAGE_W)) u_win (
         .en     (win_en[g]),
         .base_pg(win_base[g]),
         .lim_pg (win_lim[g]),
         .addr_pg(chk_addr[ADDR_W-1:PAGE_BITS]),
         .is_wr  (chk_wr),
         .hit    (win_hit[g])
      );
   end

   fg_floor #(.ADDR_W(ADDR_W)) u_floor (
      .floor_addr(floor_addr),
      .addr      (chk_addr),
      .below     (below_floor)
   );

   assign deny = below_floor | (|win_hit);

   if (REG_RESULT) begin : g_reg_res
      logic valid_q;
      logic blk_q;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q <= 1'b0;
            blk_q   <= 1'b0;
         end else begin
            valid_q <= chk_valid;
            blk_q   <= chk_valid & deny;
         end
      end

      assign res_valid   = valid_q;
      assign res_blocked = blk_q;

      // R6
      floor_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (chk_valid && chk_addr < floor_addr) |=> (res_valid && res_blocked));

      // R5
      read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (chk_valid && !chk_wr && chk_addr >= floor_addr) |=> !res_blocked);

      // R9
      result_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         chk_valid |=> res_valid);
   end else begin : g_comb_res
      assign res_valid   = chk_valid;
      assign res_blocked = chk_valid & deny;
   end

   // R9
   blk_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_blocked |-> res_valid);
endmodule

// File: tb/sim_flash_guard.sv
module sim_flash_guard;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 14;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [2:0]  cfg_idx = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        chk_valid = 1'b0;
   logic [23:0] chk_addr = '0;
   logic        chk_wr = 1'b0;
   logic        res_valid;
   logic        res_blocked;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_guard u0 (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .chk_valid(chk_valid), .chk_addr(chk_addr), .chk_wr(chk_wr),
      .res_valid(res_valid), .res_blocked(res_blocked)
   );

   // {expected blocked, is write, address}; config: floor 0x010000,
   // win0 0x100000..0x1FFFFF, win1 0x400000..0x400FFF, win2 disabled, win3 inverted
   localparam logic [25:0] VEC [NVEC] = '{
      {1'b1, 1'b0, 24'h00FFFF},   // R6 read below floor
      {1'b1, 1'b1, 24'h00FFFF},   // R6 write below floor
      {1'b0, 1'b0, 24'h010000},   // R6 read at floor
      {1'b0, 1'b1, 24'h010000},   // R6 write at floor
      {1'b0, 1'b1, 24'h0FFFFF},   // R4 before base
      {1'b1, 1'b1, 24'h100000},   // R4 first byte
      {1'b1, 1'b1, 24'h1FFFFF},   // R4 inclusive limit
      {1'b0, 1'b1, 24'h200000},   // R4 past limit
      {1'b0, 1'b0, 24'h150000},   // R5 read in window
      {1'b1, 1'b1, 24'h400FFF},   // R7 second window
      {1'b0, 1'b1, 24'h401000},   // R7 past second window
      {1'b0, 1'b1, 24'h850000},   // R3 disabled window
      {1'b0, 1'b1, 24'hA00000},   // R4 inverted window
      {1'b0, 1'b1, 24'h9FFFFF}    // R4 inverted window
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] idx, input logic [31:0] data);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_idx = idx; cfg_wdata = data;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic reg_expect(input string req, input logic [2:0] idx, input logic [31:0] exp);
      cfg_idx = idx;
      #1;
      check(req, cfg_rdata, exp);
   endtask

   task automatic probe(input string req, input logic [23:0] a, input logic w, input logic exp_blk);
      @(negedge clk);
      chk_valid = 1'b1; chk_addr = a; chk_wr = w;
      @(negedge clk);
      chk_valid = 1'b0;
      check({req, " valid"}, {31'b0, res_valid}, 32'd1);
      check({req, " blocked"}, {31'b0, res_blocked}, {31'b0, exp_blk});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 res_valid", {31'b0, res_valid}, 32'd0);
      check("R1 res_blocked", {31'b0, res_blocked}, 32'd0);
      for (int i = 0; i < 6; i++) reg_expect("R1 reg", 3'(i), 32'h0);

      // R3 nothing enabled: a write anywhere passes
      probe("R3 all disabled", 24'h100000, 1'b1, 1'b0);

      // R2 programming
      reg_write(3'd1, 32'hFF01_0000);
      reg_write(3'd2, 32'h81FF_0100);
      reg_write(3'd3, 32'h8400_0400);
      reg_write(3'd4, 32'h08FF_0800);
      reg_write(3'd5, 32'h89FF_0A00);
      reg_write(3'd0, 32'h0000_0000);
      reg_expect("R2 floor", 3'd1, 32'h0001_0000);
      reg_expect("R2 win0", 3'd2, 32'h81FF_0100);
      reg_expect("R2 win1", 3'd3, 32'h8400_0400);
      reg_expect("R2 win2", 3'd4, 32'h08FF_0800);
      reg_expect("R2 win3", 3'd5, 32'h89FF_0A00);
      reg_expect("R2 ctrl", 3'd0, 32'h0);

      for (int v = 0; v < NVEC; v++) begin
         probe("R4-table", VEC[v][23:0], VEC[v][24], VEC[v][25]);
      end

      // R9 no request, no result
      @(negedge clk);
      check("R9 idle valid", {31'b0, res_valid}, 32'd0);
      check("R9 idle blocked", {31'b0, res_blocked}, 32'd0);

      // R8 lock
      reg_write(3'd0, 32'h0000_0001);
      reg_expect("R8 lock set", 3'd0, 32'h1);
      reg_write(3'd1, 32'h0000_0000);
      reg_write(3'd2, 32'h0000_0000);
      reg_write(3'd0, 32'h0000_0000);
      reg_expect("R8 lock stays", 3'd0, 32'h1);
      reg_expect("R8 floor frozen", 3'd1, 32'h0001_0000);
      reg_expect("R8 win0 frozen", 3'd2, 32'h81FF_0100);
      probe("R8 floor still blocks", 24'h000010, 1'b0, 1'b1);
      probe("R8 window still blocks", 24'h180000, 1'b1, 1'b1);

      // R1 reset clears the lock
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      reg_expect("R1 lock cleared", 3'd0, 32'h0);
      reg_expect("R1 floor cleared", 3'd1, 32'h0);

      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=done");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end
endmodule